// File: doc/BRIEF.md
# FIFO Trigger Level Interrupt Selector

This block decides when a UART with 64-entry transmit and receive FIFOs should raise its "receive data ready" and "transmit space available" interrupt conditions. It takes the current receive fill count, the current transmit free-space count, an 8-bit programmable trigger register held inside the block, and the two 2-bit trigger fields of the older FIFO control register. From these it forms the two interrupt conditions. It also presents the two counts in the byte-wide format of the readable level registers.

The programmable trigger register has one 4-bit field per direction. A field counts in steps of four characters. When a field is non-zero, it replaces the legacy table trigger for its own direction. When a field is zero, that direction uses the legacy 2-bit decode instead. The two directions are selected independently of each other. Writes to the trigger register are accepted only when two enable bits are both set: the enhanced-function enable and the modem-control bank select. The interrupt conditions are purely combinational. They follow the counts in the same cycle.

Top module: `fifo_trig_sel`

## Requirements
- R1: After reset the trigger register holds zero, so both directions use their legacy triggers.
- R2: When trigger-register bits 7:4 hold a non-zero value N, `rxIrq` is 1 exactly while `rxCount` >= 4*N (4 to 60), and `legacyRxSel` has no effect.
- R3: When trigger-register bits 3:0 hold a non-zero value N, `txIrq` is 1 exactly while `txSpace` >= 4*N (4 to 60), and `legacyTxSel` has no effect.
- R4: When bits 7:4 are zero, the receive trigger decodes from `legacyRxSel` as 0→8, 1→16, 2→56, 3→60, and `rxIrq` is 1 exactly while `rxCount` is at or above it.
- R5: When bits 3:0 are zero, the transmit trigger decodes from `legacyTxSel` as 0→8, 1→16, 2→32, 3→56, and `txIrq` is 1 exactly while `txSpace` is at or above it.
- R6: On a rising clock edge with `trigWrEn`, `enhEn` and `bankSel` all 1, the trigger register loads `trigWrData`. With any of the three at 0, the register keeps its value.
- R7: `txLevel` reads `txSpace` (0 to 64) on bits 6:0, with bit 7 at 0.
- R8: `rxLevel` reads `rxCount` (0 to 64) on bits 6:0, with bit 7 at 0.
- R9: Both interrupt conditions are combinational. They change in the same cycle that a count crosses the threshold, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trigWrEn | input | 1 | Write strobe for the trigger register |
| trigWrData | input | 8 | Write data: bits 7:4 receive trigger, bits 3:0 transmit trigger |
| enhEn | input | 1 | Enhanced-function enable bit |
| bankSel | input | 1 | Modem-control bank select bit |
| legacyRxSel | input | 2 | Legacy receive trigger field |
| legacyTxSel | input | 2 | Legacy transmit trigger field |
| rxCount | input | 7 | Characters stored in the receive FIFO |
| txSpace | input | 7 | Free entries in the transmit FIFO |
| rxIrq | output | 1 | Receive trigger condition |
| txIrq | output | 1 | Transmit trigger condition |
| rxLevel | output | 8 | Readable receive fill level |
| txLevel | output | 8 | Readable transmit free-space level |

## Verification
A corrupted or wrongly gated trigger register is not visible directly at the ports. It shows up as a shifted threshold: the interrupt edge appears at the wrong count. It also shows up when a legacy field starts or stops mattering. For that reason the bench sweeps every count from 0 to 64 against every field value and every legacy selection. Because the conditions are combinational, a bad threshold shows up on the very first vector that crosses it. A bad register load shows up on the first vector after the clock edge that should have loaded it.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;

  typedef struct packed {
    logic loadTrig;
  } trigStrobe_t;

  // dir 0 = transmit (spaces), dir 1 = receive (characters)
  function automatic int legacyLevel(input int dir, input logic [1:0] sel);
    if (dir == 1) begin
      case (sel)
        2'd0: return 8;
        2'd1: return 16;
        2'd2: return 56;
        default: return 60;
      endcase
    end else begin
      case (sel)
        2'd0: return 8;
        2'd1: return 16;
        2'd2: return 32;
        default: return 56;
      endcase
    end
  endfunction

endpackage

// File: rtl/fifo_trig_ctrl.sv
module fifo_trig_ctrl (
  input  logic                       trigWrEn,
  input  logic                       enhEn,
  input  logic                       bankSel,
  output fifo_trig_pkg::trigStrobe_t strobe
);
  always_comb begin
    strobe.loadTrig = trigWrEn && enhEn && bankSel;
  end
endmodule

// File: rtl/fifo_trig_dp.sv
module fifo_trig_dp #(
  parameter int CNT_W     = 7,
  parameter int NIB_W     = 4,
  parameter int TRIG_STEP = 4,
  parameter int REG_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fifo_trig_pkg::trigStrobe_t strobe,
  input  logic [2*NIB_W-1:0]         trigWrData,
  input  logic [1:0]                 legacyRxSel,
  input  logic [1:0]                 legacyTxSel,
  input  logic [CNT_W-1:0]           rxCount,
  input  logic [CNT_W-1:0]           txSpace,
  output logic [2*NIB_W-1:0]         trigQ,
  output logic                       rxIrq,
  output logic                       txIrq,
  output logic [REG_W-1:0]           rxLevel,
  output logic [REG_W-1:0]           txLevel
);
  localparam int PAD_W = REG_W - CNT_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigQ <= '0;
    else if (strobe.loadTrig) trigQ <= trigWrData;
  end

  logic [1:0]       dirIrq;
  logic [CNT_W-1:0] dirCount [2];
  logic [1:0]       dirSel   [2];

  assign dirCount[0] = txSpace;
  assign dirCount[1] = rxCount;
  assign dirSel[0]   = legacyTxSel;
  assign dirSel[1]   = legacyRxSel;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [NIB_W-1:0] nib;
    logic [CNT_W-1:0] thr;
    assign nib = trigQ[d*NIB_W +: NIB_W];
    always_comb begin
      if (nib != '0) thr = CNT_W'(int'(nib) * TRIG_STEP);
      else           thr = CNT_W'(fifo_trig_pkg::legacyLevel(d, dirSel[d]));
    end
    assign dirIrq[d] = (dirCount[d] >= thr);
  end

  assign txIrq   = dirIrq[0];
  assign rxIrq   = dirIrq[1];
  assign txLevel = {{PAD_W{1'b0}}, txSpace};
  assign rxLevel = {{PAD_W{1'b0}}, rxCount};
endmodule

// File: rtl/fifo_trig_sel.sv
module fifo_trig_sel #(
  parameter int FIFO_DEPTH = 64,
  parameter int TRIG_STEP  = 4,
  parameter int NIB_W      = 4,
  parameter int REG_W      = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigWrEn,
  input  logic [2*NIB_W-1:0] trigWrData,
  input  logic               enhEn,
  input  logic               bankSel,
  input  logic [1:0]         legacyRxSel,
  input  logic [1:0]         legacyTxSel,
  input  logic [CNT_W-1:0]   rxCount,
  input  logic [CNT_W-1:0]   txSpace,
  output logic               rxIrq,
  output logic               txIrq,
  output logic [REG_W-1:0]   rxLevel,
  output logic [REG_W-1:0]   txLevel
);
  fifo_trig_pkg::trigStrobe_t strobe;
  logic [2*NIB_W-1:0]         trigQ;

  fifo_trig_ctrl u_ctrl (
    .trigWrEn(trigWrEn), .enhEn(enhEn), .bankSel(bankSel), .strobe(strobe)
  );

  fifo_trig_dp #(
    .CNT_W(CNT_W), .NIB_W(NIB_W), .TRIG_STEP(TRIG_STEP), .REG_W(REG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .trigWrData(trigWrData),
    .legacyRxSel(legacyRxSel), .legacyTxSel(legacyTxSel),
    .rxCount(rxCount), .txSpace(txSpace), .trigQ(trigQ),
    .rxIrq(rxIrq), .txIrq(txIrq), .rxLevel(rxLevel), .txLevel(txLevel)
  );
endmodule

// File: rtl/fifo_trig_sel_chk.sv
module fifo_trig_sel_chk #(
  parameter int CNT_W     = 7,
  parameter int NIB_W     = 4,
  parameter int TRIG_STEP = 4,
  parameter int REG_W     = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               trigWrEn,
  input logic [2*NIB_W-1:0] trigWrData,
  input logic               enhEn,
  input logic               bankSel,
  input logic [1:0]         legacyRxSel,
  input logic [CNT_W-1:0]   rxCount,
  input logic [CNT_W-1:0]   txSpace,
  input logic [2*NIB_W-1:0] trigQ,
  input logic               rxIrq,
  input logic               txIrq,
  input logic [REG_W-1:0]   rxLevel,
  input logic [REG_W-1:0]   txLevel
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(trigWrEn && enhEn && bankSel) |=> $stable(trigQ));

  p_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (trigWrEn && enhEn && bankSel) |=> trigQ == $past(trigWrData));

  p_rx_prog_r2: assert property (@(posedge clk) disable iff (!rstN)
    (trigQ[2*NIB_W-1:NIB_W] != '0) |->
      rxIrq == (int'(rxCount) >= int'(trigQ[2*NIB_W-1:NIB_W]) * TRIG_STEP));

  p_tx_prog_r3: assert property (@(posedge clk) disable iff (!rstN)
    (trigQ[NIB_W-1:0] != '0) |->
      txIrq == (int'(txSpace) >= int'(trigQ[NIB_W-1:0]) * TRIG_STEP));

  p_rx_top_legacy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (trigQ[2*NIB_W-1:NIB_W] == '0 && legacyRxSel == 2'd3 && rxCount < 60) |-> !rxIrq);

  p_tx_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    txLevel[REG_W-1] == 1'b0 && txLevel[CNT_W-1:0] == txSpace);

  p_rx_level_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxLevel[REG_W-1] == 1'b0 && rxLevel[CNT_W-1:0] == rxCount);
endmodule

bind fifo_trig_sel fifo_trig_sel_chk #(
  .CNT_W(CNT_W), .NIB_W(NIB_W), .TRIG_STEP(TRIG_STEP), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rstN(rstN), .trigWrEn(trigWrEn), .trigWrData(trigWrData),
  .enhEn(enhEn), .bankSel(bankSel), .legacyRxSel(legacyRxSel),
  .rxCount(rxCount), .txSpace(txSpace), .trigQ(trigQ),
  .rxIrq(rxIrq), .txIrq(txIrq), .rxLevel(rxLevel), .txLevel(txLevel)
);

// File: tb/fifo_trig_sel_tb.sv
`timescale 1ns/1ps
module fifo_trig_sel_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       trigWrEn = 1'b0;
  logic [7:0] trigWrData = '0;
  logic       enhEn = 1'b0;
  logic       bankSel = 1'b0;
  logic [1:0] legacyRxSel = '0;
  logic [1:0] legacyTxSel = '0;
  logic [6:0] rxCount = '0;
  logic [6:0] txSpace = '0;
  logic       rxIrq, txIrq;
  logic [7:0] rxLevel, txLevel;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  fifo_trig_sel u_dut (
    .clk(clk), .rstN(rstN), .trigWrEn(trigWrEn), .trigWrData(trigWrData),
    .enhEn(enhEn), .bankSel(bankSel), .legacyRxSel(legacyRxSel),
    .legacyTxSel(legacyTxSel), .rxCount(rxCount), .txSpace(txSpace),
    .rxIrq(rxIrq), .txIrq(txIrq), .rxLevel(rxLevel), .txLevel(txLevel)
  );

  function automatic int rxThr(input int nib, input int sel);
    int t [4] = '{8, 16, 56, 60};
    return (nib != 0) ? nib * 4 : t[sel];
  endfunction

  function automatic int txThr(input int nib, input int sel);
    int t [4] = '{8, 16, 32, 56};
    return (nib != 0) ? nib * 4 : t[sel];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d (rx=%0d tx=%0d)",
               req, act, exp, rxCount, txSpace);
    end
  endtask

  // One register write with the given gating, synchronous to the clock
  task automatic wrTrig(input logic [7:0] d, input logic e, input logic b);
    @(negedge clk);
    trigWrData = d; enhEn = e; bankSel = b; trigWrEn = 1'b1;
    @(negedge clk);
    trigWrEn = 1'b0; enhEn = 1'b0; bankSel = 1'b0;
  endtask

  task automatic apply(input int rc, input int ts);
    rxCount = 7'(rc); txSpace = 7'(ts);
    #0.5;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++; misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state falls back to legacy (sel 0 -> 8 both ways)
    apply(7, 7);  check("R1 rx", rxIrq, 0); check("R1 tx", txIrq, 0);
    apply(8, 8);  check("R1 rx", rxIrq, 1); check("R1 tx", txIrq, 1);

    // Full sweep: every nibble, every legacy select, every count (R2..R5, R7, R8, R9)
    for (int nib = 0; nib < 16; nib++) begin
      wrTrig(8'((nib << 4) | (15 - nib)), 1'b1, 1'b1);
      for (int sel = 0; sel < 4; sel++) begin
        legacyRxSel = 2'(sel);
        legacyTxSel = 2'(3 - sel);
        for (int c = 0; c <= 64; c++) begin
          int ts;
          ts = (c * 37) % 65;
          apply(c, ts);
          check(nib != 0 ? "R2" : "R4", rxIrq, (c >= rxThr(nib, sel)) ? 1 : 0);
          check((15 - nib) != 0 ? "R3" : "R5", txIrq,
                (ts >= txThr(15 - nib, 3 - sel)) ? 1 : 0);
          check("R8", rxLevel, c);
          check("R7", txLevel, ts);
        end
      end
    end

    // R9: conditions track counts with no clock edge in between
    wrTrig(8'h33, 1'b1, 1'b1);  // 12 both ways
    @(negedge clk);
    apply(12, 12); check("R9 rx", rxIrq, 1); check("R9 tx", txIrq, 1);
    apply(11, 11); check("R9 rx", rxIrq, 0); check("R9 tx", txIrq, 0);

    // R6: write gating, observed through the thresholds (12 stays unless loaded)
    wrTrig(8'hFF, 1'b0, 1'b1);
    apply(12, 12); check("R6 enh off rx", rxIrq, 1); check("R6 enh off tx", txIrq, 1);
    wrTrig(8'hFF, 1'b1, 1'b0);
    apply(12, 12); check("R6 bank off rx", rxIrq, 1); check("R6 bank off tx", txIrq, 1);
    @(negedge clk);
    trigWrData = 8'hFF; enhEn = 1'b1; bankSel = 1'b1; trigWrEn = 1'b0;
    @(negedge clk);
    enhEn = 1'b0; bankSel = 1'b0;
    apply(12, 12); check("R6 no strobe rx", rxIrq, 1); check("R6 no strobe tx", txIrq, 1);
    wrTrig(8'hFF, 1'b1, 1'b1);
    apply(59, 59); check("R6 load rx", rxIrq, 0); check("R6 load tx", txIrq, 0);
    apply(60, 60); check("R6 load rx", rxIrq, 1); check("R6 load tx", txIrq, 1);

    // R1 again: reset clears the register back to legacy
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    legacyRxSel = 2'd0; legacyTxSel = 2'd0;
    apply(8, 8); check("R1 after reset rx", rxIrq, 1); check("R1 after reset tx", txIrq, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule